// File: doc/BRIEF.md
# Programmable Oscillator Divider with Phase-Frequency Comparator

This block sits in the digital part of a tuning synthesizer. It takes one of two local-oscillator signals, divides it by a programmable count, and compares the divided signal with a reference strobe in a phase-frequency detector. The detector drives a three-state charge-pump control. The pump sources current (up) when the reference is ahead, sinks current (down) when the divided signal is ahead, and is released to high impedance when neither correction is pending. The analog charge pump, the loop filter and the oscillator itself lie outside the block.

One 14-bit divisor word serves both inputs. The high-band input divides by the whole word. The low-band input divides by the upper ten bits only, so the four low bits are don't-care in that band. The divisor is chosen as oscillator frequency over reference frequency: 1007 for a 100.7 MHz oscillator on a 100 kHz grid, or 145 (word 0x910) for 1450 kHz on a 10 kHz grid. Both oscillator inputs are modelled as digital levels and sampled by the system clock. The reference arrives as a one-cycle strobe in that same clock domain.

Top module: `pll_divpfd`

## Requirements
- R1: While reset is asserted and on the first sampling after it, pump_up, pump_dn and pump_drive are 0.
- R2: With band_fm=1 the divider counts rising edges of fm_osc (low on one clock edge, high on the next). Every div_word[13:0]-th edge ends a period. Edges on am_osc are ignored.
- R3: With band_fm=0 the divider counts rising edges of am_osc and each period is div_word[13:4] edges long. Bits 3:0 and fm_osc edges have no effect.
- R4: A selected divisor value of 0 or 1 behaves as 2.
- R5: The divisor for a period is taken at the terminal edge of the previous period, or at the first counted edge after reset or a band change. Changing div_word mid-period does not alter the period in progress.
- R6: A reference strobe raises pump_up on the next clock. pump_up stays high until the divided signal ends a period.
- R7: The divided signal ends a period on the edge that is sampled. pump_dn rises two clocks after that edge and stays high until a reference strobe arrives.
- R8: pump_up and pump_dn are never high together. When the pending event of one side meets a new event of the other side, both fall on the same clock.
- R9: pump_drive is 1 exactly when pump_up or pump_dn is 1. A 0 on pump_drive means the pump output is in high impedance.
- R10: A change of band_fm clears both pump outputs on the next clock and restarts the count from zero, so no spurious correction pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| fm_osc | input | 1 | High-band oscillator level |
| am_osc | input | 1 | Low-band oscillator level |
| div_word | input | 14 | Divisor word; high band uses all bits, low band bits 13:4 |
| band_fm | input | 1 | 1 selects fm_osc, 0 selects am_osc |
| ref_stb | input | 1 | One-cycle reference strobe |
| pump_up | output | 1 | Charge pump source request |
| pump_dn | output | 1 | Charge pump sink request |
| pump_drive | output | 1 | Pump output enable; 0 means high impedance |

## Verification
A wrong count or a divisor latched at the wrong time shows at the ports as pump_dn rising an edge early or late, or as pump_up being released at the wrong edge. This appears within one divide period of the fault. A detector flop stuck or cleared wrongly shows within one clock as an up or down level that the edge-by-edge reference model does not predict. A missed clear on band change shows one clock after the change as a pump output left active, and in the next period as a short count. The bench compares every cycle against a model driven by the same stimulus, and adds directed edge counts for the band, clamp, latch and coincidence cases.

// File: rtl/pllsyn_pkg.sv
`timescale 1ns/1ps
package pllsyn_pkg;

   typedef enum logic {
      BAND_LO = 1'b0,
      BAND_HI = 1'b1
   } band_e;

   localparam int unsigned OSC_COUNT = 2;

endpackage

// File: rtl/pllsyn_osc_tick.sv
`timescale 1ns/1ps
module pllsyn_osc_tick #(
   parameter int unsigned N_IN = 2,
   localparam int unsigned SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  osc,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   logic [N_IN-1:0] osc_q;
   logic [N_IN-1:0] rise;

   initial begin
      assert (N_IN >= 1) else $error("pllsyn_osc_tick: N_IN must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) osc_q <= '0;
      else        osc_q <= osc;
   end

   for (genvar i = 0; i < int'(N_IN); i++) begin : g_rise
      assign rise[i] = osc[i] & ~osc_q[i];
   end

   assign tick = rise[sel];

   // a rising edge cannot repeat on consecutive clocks
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise[0] |=> !rise[0]);

endmodule

// File: rtl/pllsyn_div_cnt.sv
`timescale 1ns/1ps
module pllsyn_div_cnt #(
   parameter int unsigned DIV_W   = 14,
   parameter int unsigned MIN_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [DIV_W-1:0] n_req,
   output logic             div_pulse
);

   localparam logic [DIV_W-1:0] N_FLOOR = DIV_W'(MIN_DIV);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] n_cur;
   logic [DIV_W-1:0] n_clamp;
   logic [DIV_W-1:0] n_lim;
   logic             fresh;
   logic             term;

   initial begin
      assert (MIN_DIV >= 2) else $error("pllsyn_div_cnt: MIN_DIV below 2 stalls the divider");
      assert (DIV_W >= 2 && DIV_W <= 31) else $error("pllsyn_div_cnt: DIV_W out of range");
   end

   assign n_clamp = (n_req < N_FLOOR) ? N_FLOOR : n_req;
   assign n_lim   = fresh ? n_clamp : n_cur;
   assign term    = tick && (cnt == (n_lim - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         n_cur     <= N_FLOOR;
         fresh     <= 1'b1;
         div_pulse <= 1'b0;
      end else if (clr) begin
         cnt       <= '0;
         fresh     <= 1'b1;
         div_pulse <= 1'b0;
      end else begin
         div_pulse <= term;
         if (tick) begin
            fresh <= 1'b0;
            if (term) begin
               cnt   <= '0;
               n_cur <= n_clamp;
            end else begin
               cnt   <= cnt + 1'b1;
               n_cur <= n_lim;
            end
         end
      end
   end

   // latched divisor never drops below the floor
   assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fresh |-> (n_cur >= N_FLOOR));

   // divisor only moves on a counted edge or a restart
   assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr && !fresh) |=> $stable(n_cur));

   // count stays below the active limit
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fresh |-> (cnt < n_cur));

   // period end is a single-cycle pulse
   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

endmodule

// File: rtl/pllsyn_pfd.sv
`timescale 1ns/1ps
module pllsyn_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ref_ev,
   input  logic fb_ev,
   output logic up,
   output logic dn
);

   logic up_nx;
   logic dn_nx;

   assign up_nx = up | ref_ev;
   assign dn_nx = dn | fb_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else if (clr || (up_nx && dn_nx)) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else begin
         up <= up_nx;
         dn <= dn_nx;
      end
   end

   assert_never_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn));

   assert_ref_sets_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_ev && !dn && !fb_ev && !clr) |=> up);

   assert_up_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !fb_ev && !clr) |=> up);

   assert_dn_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !ref_ev && !clr) |=> dn);

endmodule

// File: rtl/pll_divpfd.sv
`timescale 1ns/1ps
module pll_divpfd #(
   parameter int unsigned DIV_W   = 14,
   parameter int unsigned AM_LSB  = 4,
   parameter int unsigned MIN_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fm_osc,
   input  logic             am_osc,
   input  logic [DIV_W-1:0] div_word,
   input  logic             band_fm,
   input  logic             ref_stb,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             pump_drive
);
   import pllsyn_pkg::*;

   localparam int unsigned AM_W = DIV_W - AM_LSB;

   band_e            band_now;
   band_e            band_q;
   logic             band_chg;
   logic [1:0]       osc_vec;
   logic             lo_tick;
   logic [DIV_W-1:0] n_hi;
   logic [DIV_W-1:0] n_lo;
   logic [DIV_W-1:0] n_sel;
   logic             fb_pulse;

   initial begin
      assert (AM_LSB < DIV_W - 1) else $error("pll_divpfd: AM field must keep two bits");
      assert (OSC_COUNT == 2) else $error("pll_divpfd: exactly two oscillator inputs expected");
   end

   assign band_now = band_fm ? BAND_HI : BAND_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) band_q <= BAND_LO;
      else        band_q <= band_now;
   end

   assign band_chg = (band_now != band_q);

   // index 0 = low band input, index 1 = high band input
   assign osc_vec = {fm_osc, am_osc};

   pllsyn_osc_tick #(.N_IN(OSC_COUNT)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .osc   (osc_vec),
      .sel   (band_now),
      .tick  (lo_tick)
   );

   assign n_hi = div_word;

   if (AM_LSB == 0) begin : g_lo_full
      assign n_lo = div_word;
   end else begin : g_lo_field
      assign n_lo = {{AM_LSB{1'b0}}, div_word[DIV_W-1 -: AM_W]};
   end

   assign n_sel = (band_now == BAND_HI) ? n_hi : n_lo;

   pllsyn_div_cnt #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (band_chg),
      .tick      (lo_tick),
      .n_req     (n_sel),
      .div_pulse (fb_pulse)
   );

   pllsyn_pfd u_pfd (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (band_chg),
      .ref_ev (ref_stb),
      .fb_ev  (fb_pulse),
      .up     (pump_up),
      .dn     (pump_dn)
   );

   assign pump_drive = pump_up | pump_dn;

   // a band switch leaves no correction pending
   assert_band_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      band_chg |=> (!pump_up && !pump_dn && !fb_pulse));

   // drive is released whenever both requests are idle one clock after a clear
   assert_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      band_chg |=> !pump_drive);

endmodule

// File: tb/pll_divpfd_tb.sv
`timescale 1ns/1ps
module pll_divpfd_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fm_osc = 1'b0, am_osc = 1'b0, ref_stb = 1'b0;
   logic [13:0] divw = 14'd2;
   logic        band = 1'b1;
   logic        pump_up, pump_dn, pump_drive;

   int checks = 0;
   int failures = 0;

   // reference model state
   logic m_fmq, m_amq, m_sel, m_fresh, m_divp, m_up, m_dn;
   int   m_cnt, m_ncur;

   always #2.5 clk = ~clk;

   pll_divpfd u_dut (
      .clk(clk), .rst_n(rst_n), .fm_osc(fm_osc), .am_osc(am_osc),
      .div_word(divw), .band_fm(band), .ref_stb(ref_stb),
      .pump_up(pump_up), .pump_dn(pump_dn), .pump_drive(pump_drive)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int eff_div(input logic b, input logic [13:0] w);
      int n;
      n = b ? int'(w) : int'(w >> 4);
      if (n < 2) n = 2;
      return n;
   endfunction

   task automatic model_reset();
      m_fmq = 0; m_amq = 0; m_sel = 0; m_fresh = 1; m_divp = 0;
      m_up = 0; m_dn = 0; m_cnt = 0; m_ncur = 2;
   endtask

   task automatic model_step(input logic fm, input logic am, input logic rf);
      logic tick, nu, nd;
      int neff, nact;
      tick = band ? (fm && !m_fmq) : (am && !m_amq);
      neff = eff_div(band, divw);
      nu = m_up | rf;
      nd = m_dn | m_divp;
      if (band != m_sel) begin
         m_cnt = 0; m_fresh = 1; m_divp = 0; m_up = 0; m_dn = 0;
      end else begin
         if (nu && nd) begin m_up = 0; m_dn = 0; end
         else begin m_up = nu; m_dn = nd; end
         if (tick) begin
            nact = m_fresh ? neff : m_ncur;
            if (m_cnt == nact - 1) begin m_divp = 1; m_cnt = 0; m_ncur = neff; end
            else begin m_divp = 0; m_cnt = m_cnt + 1; m_ncur = nact; end
            m_fresh = 0;
         end else m_divp = 0;
      end
      m_fmq = fm; m_amq = am; m_sel = band;
   endtask

   // one clock: drive at negedge, sample at next negedge, compare with model
   task automatic cyc(input logic fm, input logic am, input logic rf);
      fm_osc = fm; am_osc = am; ref_stb = rf;
      model_step(fm, am, rf);
      @(posedge clk);
      @(negedge clk);
      check(pump_up == m_up, "R6 model up", int'(pump_up), int'(m_up));
      check(pump_dn == m_dn, "R7 model dn", int'(pump_dn), int'(m_dn));
      check(pump_drive == (m_up | m_dn), "R9 model drive", int'(pump_drive), int'(m_up | m_dn));
   endtask

   task automatic do_reset();
      rst_n = 1'b0; fm_osc = 0; am_osc = 0; ref_stb = 0;
      model_reset();
      @(negedge clk);
      check(!pump_up && !pump_dn && !pump_drive, "R1 in reset",
            int'({pump_up, pump_dn, pump_drive}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0);
   endtask

   // one edge on the active input (other input mirrors it when noise is set), then low
   task automatic edge_pair(input bit noise);
      cyc(band ? 1'b1 : noise, band ? noise : 1'b1, 0);
      cyc(0, 0, 0);
   endtask

   task automatic count_edges(input int limit, input bit noise, output int n);
      n = 0;
      for (int k = 1; k <= limit; k++) begin
         edge_pair(noise);
         if (pump_dn) begin n = k; break; end
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int n;
      @(negedge clk);
      // R1
      band = 1; divw = 5;
      do_reset();
      check(!pump_up && !pump_dn && !pump_drive, "R1 after reset",
            int'({pump_up, pump_dn, pump_drive}), 0);

      // R2: high band divides by the full word, low-band edges ignored
      count_edges(50, 1, n);
      check(n == 5, "R2 divide by 5 with am noise", n, 5);
      band = 1; divw = 14'h3EF; do_reset();
      count_edges(1100, 0, n);
      check(n == 1007, "R2 divide by 0x3EF", n, 1007);

      // R3: low band uses bits 13:4, fm edges ignored
      band = 0; divw = 14'h91F; do_reset();
      count_edges(300, 1, n);
      check(n == 145, "R3 divide by word 0x91F field", n, 145);

      // R4: clamp
      band = 1; divw = 0; do_reset();
      count_edges(10, 0, n);
      check(n == 2, "R4 divisor 0", n, 2);
      divw = 1; do_reset();
      count_edges(10, 0, n);
      check(n == 2, "R4 divisor 1", n, 2);
      band = 0; divw = 14'h01F; do_reset();
      count_edges(10, 0, n);
      check(n == 2, "R4 low band field 1", n, 2);

      // R5: mid-period change waits for terminal count
      band = 1; divw = 6; do_reset();
      edge_pair(0); edge_pair(0);
      divw = 3;
      count_edges(20, 0, n);
      check(n == 4, "R5 period in progress keeps 6", n, 4);
      cyc(0, 0, 1);
      check(!pump_drive, "R8 ref meets pending dn", int'(pump_drive), 0);
      count_edges(20, 0, n);
      check(n == 3, "R5 new divisor next period", n, 3);

      // R6 / R9: reference leads
      band = 1; divw = 2; do_reset();
      cyc(0, 0, 1);
      check(pump_up && !pump_dn && pump_drive, "R6 up after strobe",
            int'({pump_up, pump_dn, pump_drive}), 3'b101);
      cyc(0, 0, 0); cyc(0, 0, 0);
      check(pump_up, "R6 up held", int'(pump_up), 1);
      edge_pair(0);
      check(pump_up, "R6 up held mid period", int'(pump_up), 1);
      cyc(1, 0, 0); cyc(0, 0, 0);
      check(!pump_up && !pump_drive, "R9 released after period end",
            int'({pump_up, pump_drive}), 0);

      // R8: coincident events
      do_reset();
      cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0);
      cyc(0, 0, 1);
      check(!pump_up && !pump_dn && !pump_drive, "R8 coincident",
            int'({pump_up, pump_dn, pump_drive}), 0);
      cyc(0, 0, 0);
      check(!pump_drive, "R8 stays idle", int'(pump_drive), 0);

      // R10: band change clears and restarts
      band = 1; divw = 4; do_reset();
      edge_pair(0); edge_pair(0); edge_pair(0);
      band = 0; cyc(0, 0, 0);
      band = 1; cyc(0, 0, 0);
      count_edges(20, 0, n);
      check(n == 4, "R10 count restarts", n, 4);
      band = 0; cyc(0, 0, 0);
      check(!pump_dn && !pump_drive, "R10 dn cleared", int'({pump_dn, pump_drive}), 0);
      band = 1; cyc(0, 0, 1);
      band = 0; cyc(0, 0, 0);
      check(!pump_up && !pump_drive, "R10 up cleared", int'({pump_up, pump_drive}), 0);

      // random phase against model
      void'($urandom(32'd1234));
      band = 1; divw = 7; do_reset();
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 60 == 0)
            divw = ($urandom % 2) ? 14'($urandom % 24) : 14'($urandom % 400);
         if ($urandom % 500 == 0) band = ~band;
         cyc(1'($urandom % 2), 1'($urandom % 2), ($urandom % 17) == 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule